// File: doc/BRIEF.md
# Mode-Aware Bidirectional GPIO Port

This block is an 8-bit general-purpose I/O port with three byte-wide registers reached over a simple register bus: a pin direction register, an output data latch and a pull-up enable register. The bus has an address, a write strobe, a read strobe and write and read data lines. In single-chip mode each pin is a general input or output, chosen by its direction bit. The block drives per-pin output enables, output values and pull-up enables. It samples the pin levels through a two-stage synchroniser.

The 2-bit operating mode input can hand all eight pins to an external data bus, either expanded mode. The direction register then has no effect. The pins follow the bus controller's drive request and data, and they float while reset or either standby input is active.

Hardware standby clears the direction settings. Software standby keeps them, so output pins keep driving in single-chip mode. Neither standby accepts register writes.

Top module: `gpio_port_mode`

## Requirements
- R1: While reset is asserted and after it is released, the direction, data and pull-up registers all read as 0 (direction seen through the pins), and no pin output enable or pull-up enable is asserted.
- R2: A read of the direction register (address 16'hFFB4) always returns 8'hFF, whatever value was last written.
- R3: A write to 16'hFFB4 loads the direction register, a write to 16'hFFB6 loads the data latch, and a write to 16'hFFAE loads the pull-up register, which reads back its stored value.
- R4: In single-chip mode (mode 2'b00 or 2'b11), with no hardware standby, pin_oe equals the direction register bit for bit and pin_out equals the data latch.
- R5: In single-chip mode a read of the data register returns the latch bit for each output pin (direction 1) and the synchronised pin level for each input pin (direction 0). A pin level first appears in the read two rising clock edges after it is applied. In the expanded modes the read returns the latch.
- R6: pin_pu for a bit is 1 only when its pull-up bit is 1, its direction bit is 0, the mode is single-chip and hardware standby is low.
- R7: In the expanded modes (mode 2'b01 or 2'b10) the direction register is ignored. When the pins are not floating, every pin_oe bit equals xbus_drive, pin_out equals xbus_dout and pin_pu is 0. xbus_din always equals pin_in.
- R8: In the expanded modes all pin_oe bits are 0 while reset, hardware standby or software standby is asserted.
- R9: While hardware standby is asserted pin_oe is 0. The direction register is cleared at the first rising clock edge with hardware standby high, so pins stay inputs after it is released.
- R10: Software standby keeps the direction register. In single-chip mode the output pins keep driving the latch value through it.
- R11: Register writes have no effect while either standby is asserted. Writes to any address other than the three register addresses have no effect, and reads of such addresses return 8'hFF.
- R12: reg_rdata is 8'h00 whenever reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| mode | input | 2 | Operating mode: 01/10 expanded, 00/11 single-chip |
| reg_addr | input | 16 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| xbus_drive | input | 1 | External bus controller requests the pins to drive |
| xbus_dout | input | 8 | External bus data to drive onto the pins |
| xbus_din | output | 8 | Pin levels handed to the external bus |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Per-pin output enables |
| pin_pu | output | 8 | Per-pin pull-up enables |

## Verification
The pin mux is driven with a mixed direction pattern (0x0F, later 0xF0) against a data latch of 0xA5. This separates bits that follow the latch from bits that follow the synchroniser, and a swapped or inverted direction term shows up on pin_oe and in the merged read. Pin levels are changed one cycle apart while the data register is read on every cycle, so an off-by-one in the synchroniser depth shows. Each expanded mode is tried with drive requested and released and with each float condition. Pull-up enables are checked with all pull-up bits set, so only the direction and mode gating decide which bits appear.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE_A = 2'b00,
    MODE_BUS_NOROM = 2'b01,
    MODE_BUS_ROM = 2'b10,
    MODE_SINGLE_B = 2'b11
  } port_mode_e;

  // True when the pins are handed to the external data bus.
  function automatic logic is_bus_mode(input logic [1:0] m);
    return (m == MODE_BUS_NOROM) || (m == MODE_BUS_ROM);
  endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] A_DIR = 16'hFFB4,
  parameter logic [AW-1:0] A_DAT = 16'hFFB6,
  parameter logic [AW-1:0] A_PU  = 16'hFFAE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  dat_q,
  output logic [W-1:0]  pu_q,
  output logic          hit_dir,
  output logic          hit_dat,
  output logic          hit_pu
);
  logic wr_ok;

  assign hit_dir = (addr == A_DIR);
  assign hit_dat = (addr == A_DAT);
  assign hit_pu  = (addr == A_PU);
  assign wr_ok   = wr && !hw_stby && !sw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (hw_stby) dir_q <= '0;
    else if (wr_ok && hit_dir) dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dat_q <= '0;
    else if (wr_ok && hit_dat) dat_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pu_q <= '0;
    else if (wr_ok && hit_pu) pu_q <= wdata;
  end
endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
  parameter int W = 8
) (
  input  logic         bus_mode,
  input  logic         rst_n,
  input  logic         hw_stby,
  input  logic         sw_stby,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] pu_q,
  input  logic         xbus_drive,
  input  logic [W-1:0] xbus_dout,
  output logic [W-1:0] oe,
  output logic [W-1:0] out,
  output logic [W-1:0] pu_en
);
  logic bus_float;

  assign bus_float = !rst_n || hw_stby || sw_stby;

  always_comb begin
    if (bus_mode) begin
      oe    = bus_float ? '0 : {W{xbus_drive}};
      out   = xbus_dout;
      pu_en = '0;
    end else begin
      oe    = hw_stby ? '0 : dir_q;
      out   = dat_q;
      pu_en = hw_stby ? '0 : (pu_q & ~dir_q);
    end
  end
endmodule

// File: rtl/gpio_port_mode.sv
module gpio_port_mode
  import gpio_port_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] A_DIR = 16'hFFB4,
  parameter logic [AW-1:0] A_DAT = 16'hFFB6,
  parameter logic [AW-1:0] A_PU  = 16'hFFAE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          xbus_drive,
  input  logic [W-1:0]  xbus_dout,
  output logic [W-1:0]  xbus_din,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_pu
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  // Named internal state, visible to the bound checker.
  logic [W-1:0] dir_q, dat_q, pu_q, pin_sync;
  logic         hit_dir, hit_dat, hit_pu, bus_mode;

  // Output pins take the latch, input pins take the synchronised level.
  function automatic logic [W-1:0] merge_read(input logic [W-1:0] lat,
                                              input logic [W-1:0] dir,
                                              input logic [W-1:0] lvl);
    return (lat & dir) | (lvl & ~dir);
  endfunction

  assign bus_mode = is_bus_mode(mode);
  assign xbus_din = pin_in;

  gpio_port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_port_regs #(.W(W), .AW(AW), .A_DIR(A_DIR), .A_DAT(A_DAT), .A_PU(A_PU)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dir_q(dir_q), .dat_q(dat_q), .pu_q(pu_q),
    .hit_dir(hit_dir), .hit_dat(hit_dat), .hit_pu(hit_pu)
  );

  gpio_port_pinmux #(.W(W)) u_mux (
    .bus_mode(bus_mode), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .dir_q(dir_q), .dat_q(dat_q), .pu_q(pu_q),
    .xbus_drive(xbus_drive), .xbus_dout(xbus_dout),
    .oe(pin_oe), .out(pin_out), .pu_en(pin_pu)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit_dir)      reg_rdata = ALL_ONES;
      else if (hit_dat) reg_rdata = bus_mode ? dat_q : merge_read(dat_q, dir_q, pin_sync);
      else if (hit_pu)  reg_rdata = pu_q;
      else              reg_rdata = ALL_ONES;
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] A_DIR = 16'hFFB4,
  parameter logic [AW-1:0] A_DAT = 16'hFFB6,
  parameter logic [AW-1:0] A_PU  = 16'hFFAE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hw_stby,
  input logic          sw_stby,
  input logic [1:0]    mode,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [W-1:0]  reg_rdata,
  input logic [W-1:0]  pin_oe,
  input logic [W-1:0]  pin_pu,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  dat_q,
  input logic [W-1:0]  pu_q
);
  logic bus_m, unmapped;
  assign bus_m    = (mode == 2'b01) || (mode == 2'b10);
  assign unmapped = (reg_addr != A_DIR) && (reg_addr != A_DAT) && (reg_addr != A_PU);

  assert_dir_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DIR) |-> reg_rdata == {W{1'b1}});

  assert_pu_input_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & dir_q) == '0);

  assert_bus_no_pullup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_m |-> pin_pu == '0);

  assert_bus_float_stby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_m && (hw_stby || sw_stby)) |-> pin_oe == '0);

  assert_hw_clears_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> dir_q == '0);

  assert_hw_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> pin_oe == '0);

  assert_sw_keeps_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> $stable(dir_q));

  assert_stby_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> ($stable(dat_q) && $stable(pu_q)));

  assert_unmapped_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && unmapped && !hw_stby) |=> ($stable(dir_q) && $stable(dat_q) && $stable(pu_q)));

  assert_idle_rdata_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0);
endmodule

bind gpio_port_mode gpio_port_chk #(.W(W), .AW(AW), .A_DIR(A_DIR), .A_DAT(A_DAT), .A_PU(A_PU)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby), .mode(mode),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .pin_oe(pin_oe), .pin_pu(pin_pu), .dir_q(dir_q), .dat_q(dat_q), .pu_q(pu_q)
);

// File: tb/test_gpio_port_mode.sv
`timescale 1ns/1ps
module test_gpio_port_mode;
  logic        clk = 1'b0;
  logic        rst_n, hw_stby, sw_stby, reg_wr, reg_rd, xbus_drive;
  logic [1:0]  mode;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata, xbus_dout, xbus_din, pin_in, pin_out, pin_oe, pin_pu;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Reference model state
  int m_dir, m_dat, m_pu, m_s1, m_s2;

  always #10 clk = ~clk;

  gpio_port_mode i_gpio_port_mode (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby), .mode(mode),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xbus_drive(xbus_drive), .xbus_dout(xbus_dout),
    .xbus_din(xbus_din), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  function automatic bit bus_m();
    return mode == 2'b01 || mode == 2'b10;
  endfunction

  task automatic chk(input string nm, input logic [7:0] act, input int exp);
    n_cmp++;
    if (act !== exp[7:0]) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, nm, act, exp[7:0]);
    end
  endtask

  task automatic compare();
    int e_oe, e_out, e_pu, e_rd;
    if (!rst_n) begin m_dir = 0; m_dat = 0; m_pu = 0; m_s1 = 0; m_s2 = 0; end
    if (bus_m()) begin
      e_oe  = (!rst_n || hw_stby || sw_stby || !xbus_drive) ? 0 : 255;
      e_out = xbus_dout;
      e_pu  = 0;
    end else begin
      e_oe  = hw_stby ? 0 : m_dir;
      e_out = m_dat;
      e_pu  = 0;
      if (!hw_stby)
        for (int i = 0; i < 8; i++)
          if (m_pu[i] && !m_dir[i]) e_pu |= (1 << i);
    end
    e_rd = 0;
    if (reg_rd) begin
      case (reg_addr)
        16'hFFB4: e_rd = 255;
        16'hFFAE: e_rd = m_pu;
        16'hFFB6: begin
          if (bus_m()) e_rd = m_dat;
          else for (int i = 0; i < 8; i++)
            if (m_dir[i] ? m_dat[i] : m_s2[i]) e_rd |= (1 << i);
        end
        default: e_rd = 255;
      endcase
    end
    chk("pin_oe", pin_oe, e_oe);
    chk("pin_out", pin_out, e_out);
    chk("pin_pu", pin_pu, e_pu);
    chk("reg_rdata", reg_rdata, e_rd);
    chk("xbus_din", xbus_din, pin_in);
  endtask

  task automatic model_edge();
    if (!rst_n) begin m_dir = 0; m_dat = 0; m_pu = 0; m_s1 = 0; m_s2 = 0; return; end
    m_s2 = m_s1;
    m_s1 = pin_in;
    if (hw_stby) m_dir = 0;
    else if (!sw_stby && reg_wr) begin
      if (reg_addr == 16'hFFB4) m_dir = reg_wdata;
      if (reg_addr == 16'hFFB6) m_dat = reg_wdata;
      if (reg_addr == 16'hFFAE) m_pu  = reg_wdata;
    end
  endtask

  // Inputs are set at a falling edge; compare, then advance one clock.
  task automatic cyc();
    #2 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; cyc(); reg_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a);
    reg_addr = a; reg_rd = 1; cyc(); reg_rd = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; hw_stby = 0; sw_stby = 0; mode = 2'b11; reg_addr = 0; reg_wr = 0;
    reg_rd = 0; reg_wdata = 0; xbus_drive = 0; xbus_dout = 0; pin_in = 8'h00;
    m_dir = 0; m_dat = 0; m_pu = 0; m_s1 = 0; m_s2 = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    cur_req = "R1"; cyc(); cyc();
    rst_n = 1;
    cur_req = "R1"; rd(16'hFFAE); rd(16'hFFB6); cyc();
    cur_req = "R2"; rd(16'hFFB4);

    // Single-chip register writes and pin mux
    cur_req = "R3"; wr(16'hFFB4, 8'h0F); wr(16'hFFB6, 8'hA5); wr(16'hFFAE, 8'hFF);
    cur_req = "R3"; rd(16'hFFAE);
    cur_req = "R4"; cyc();
    cur_req = "R6"; cyc();
    cur_req = "R2"; rd(16'hFFB4);
    cur_req = "R5";
    pin_in = 8'h3C; rd(16'hFFB6); rd(16'hFFB6); rd(16'hFFB6);
    pin_in = 8'hC3; rd(16'hFFB6);
    pin_in = 8'h5A; rd(16'hFFB6); rd(16'hFFB6); rd(16'hFFB6);
    mode = 2'b00;
    cur_req = "R4"; cyc(); rd(16'hFFB6);
    mode = 2'b11;

    // Unmapped addresses
    cur_req = "R11"; wr(16'hFFB5, 8'h00); wr(16'h0000, 8'h00); rd(16'hFFB5); rd(16'hFFAF); cyc();
    cur_req = "R12"; cyc();

    // Software standby: keeps direction and drive, ignores writes
    sw_stby = 1;
    cur_req = "R10"; cyc(); cyc();
    cur_req = "R11"; wr(16'hFFB4, 8'h00); wr(16'hFFB6, 8'h00); wr(16'hFFAE, 8'h00); cyc();
    sw_stby = 0;
    cur_req = "R10"; cyc(); rd(16'hFFB6); rd(16'hFFAE);

    // Hardware standby: clears direction, pins released
    hw_stby = 1;
    cur_req = "R9"; cyc(); cyc(); wr(16'hFFB4, 8'hFF);
    hw_stby = 0;
    cur_req = "R9"; cyc(); rd(16'hFFB6);
    cur_req = "R6"; cyc();

    // Expanded modes
    wr(16'hFFB4, 8'hF0);
    cur_req = "R7";
    mode = 2'b01; xbus_dout = 8'h5A; xbus_drive = 1; cyc();
    pin_in = 8'h96; cyc(); rd(16'hFFB6);
    xbus_drive = 0; cyc();
    mode = 2'b10; xbus_drive = 1; xbus_dout = 8'hE7; cyc();
    xbus_drive = 0; cyc(); xbus_drive = 1; cyc();
    cur_req = "R8";
    sw_stby = 1; cyc(); cyc(); sw_stby = 0; cyc();
    hw_stby = 1; cyc(); hw_stby = 0; cyc();
    mode = 2'b01; rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    cur_req = "R1"; mode = 2'b11; cyc(); rd(16'hFFAE); rd(16'hFFB6);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule